// File: doc/BRIEF.md
# Tagged Local-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps its prediction from that branch's own recent outcomes. A direct-mapped history cache is selected by low branch-address bits. Each cache entry holds a valid flag, a partial address tag and a short shift register with the latest outcomes of the branch that owns the entry. On a tag hit, that history is XORed with the same number of low address bits. The result selects one 2-bit saturating counter in a single table that all branches share, and the counter's upper bit gives the predicted direction.

The fetch side is purely combinational: a branch address goes in, and a hit flag and a predicted direction come out, both read from the state left by the last clock edge. The resolve side is a one-cycle strobe that carries the branch address and the real outcome. On a hit, it trains the selected counter and shifts the outcome into the history. On a miss, it claims the entry for the new branch. Because the tags are partial, two branches can alias onto one entry. This costs only accuracy, never correctness.

Top module: `local_branch_predictor`

## Requirements
- R1: After reset, every cache entry is invalid and every counter holds 2'b10 (weakly taken); encoding 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken.
- R2: When the fetch address misses, `fetch_hit` is 0 and `fetch_taken` is 1.
- R3: A fetch hits when the entry selected by address bits [11:2] is valid and its tag equals address bits [19:12]; address bits above 19 are not compared, so aliasing branches hit.
- R4: On a hit, `fetch_taken` is the upper bit of counter number (entry history XOR address bits [7:2]).
- R5: A resolve that hits increments the selected counter on taken and decrements it on not-taken, saturating at 2'b11 and 2'b00.
- R6: A resolve that hits shifts the outcome into bit 0 of the entry history (1 = taken), dropping the oldest bit.
- R7: A resolve that misses writes the new tag, marks the entry valid, sets the history to all zeros with the outcome in bit 0, and leaves every counter unchanged.
- R8: With `res_valid` low, the `res_addr` and `res_taken` inputs change no state.
- R9: The history and the counter index are both 6 bits wide, so 64 counters are shared by all 1024 cache entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr | input | 32 | Branch address to predict |
| fetch_hit | output | 1 | Entry is valid and its tag matches |
| fetch_taken | output | 1 | Predicted direction, 1 = taken |
| res_valid | input | 1 | Resolve strobe, one cycle per branch |
| res_addr | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The main walk drives one branch through runs of not-taken outcomes that hold its history at zero. This shows the counter stepping down and saturating, separately from the history. Taken outcomes then move the history and steer the branch onto other counters. Further branches with chosen low address bits are allocated so that they land on a counter another branch has trained, which exposes both the saturation limits and the sharing of the table. The tag cases tell apart a conflicting tag (a miss and an eviction) from a difference only in address bits above the tag (a false hit). Directed cases check the reset state again after activity, and check that resolve inputs are ignored while the strobe is low.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

    typedef logic [1:0] sat2_t;

    localparam sat2_t CTR_RESET = 2'b10;

    function automatic sat2_t sat2_step(input sat2_t cur, input logic taken);
        sat2_t nxt;
        nxt = cur;
        if (taken && cur != 2'b11) begin
            nxt = cur + 2'd1;
        end else if (!taken && cur != 2'b00) begin
            nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/lbp_hist_cache.sv
module lbp_hist_cache #(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 8,
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_taken,
    output logic              wr_hit,
    output logic [HIST_W-1:0] wr_hist
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [HIST_W-1:0] hist;
    } slot_t;

    slot_t slot_q [DEPTH];
    slot_t slot_d [DEPTH];

    slot_t rd_slot;
    slot_t wr_slot;

    always_comb begin
        rd_slot = slot_q[rd_idx];
        wr_slot = slot_q[wr_idx];
        rd_hit  = rd_slot.vld && (rd_slot.tag == rd_tag);
        rd_hist = rd_slot.hist;
        wr_hit  = wr_slot.vld && (wr_slot.tag == wr_tag);
        wr_hist = wr_slot.hist;
    end

    always_comb begin
        slot_d = slot_q;
        if (wr_en) begin
            if (wr_hit) begin
                slot_d[wr_idx].hist = {wr_slot.hist[HIST_W-2:0], wr_taken};
            end else begin
                slot_d[wr_idx].vld  = 1'b1;
                slot_d[wr_idx].tag  = wr_tag;
                slot_d[wr_idx].hist = {{(HIST_W-1){1'b0}}, wr_taken};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            slot_q <= slot_d;
        end
    end

    p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit) |=>
            slot_q[$past(wr_idx)].hist == {$past(wr_hist[HIST_W-2:0]), $past(wr_taken)});

    p_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit) |=>
            (slot_q[$past(wr_idx)].vld && slot_q[$past(wr_idx)].tag == $past(wr_tag)
             && slot_q[$past(wr_idx)].hist == {{(HIST_W-1){1'b0}}, $past(wr_taken)}));

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> slot_q[$past(rd_idx)] == $past(rd_slot));

endmodule

// File: rtl/lbp_ctr_table.sv
module lbp_ctr_table
    import lbp_pkg::*;
#(
    parameter int CIDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CIDX_W-1:0] rd_idx,
    output logic              rd_taken,
    input  logic              upd_en,
    input  logic [CIDX_W-1:0] upd_idx,
    input  logic              upd_taken
);
    localparam int NCTR = 1 << CIDX_W;

    sat2_t ctr_q [NCTR];
    sat2_t ctr_d [NCTR];
    sat2_t upd_cur;

    always_comb begin
        rd_taken = ctr_q[rd_idx][1];
        upd_cur  = ctr_q[upd_idx];
        ctr_d    = ctr_q;
        if (upd_en) begin
            ctr_d[upd_idx] = sat2_step(upd_cur, upd_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCTR; i++) begin
                ctr_q[i] <= CTR_RESET;
            end
        end else begin
            ctr_q <= ctr_d;
        end
    end

    p_sat_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken && upd_cur == 2'b11) |=> ctr_q[$past(upd_idx)] == 2'b11);

    p_sat_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken && upd_cur == 2'b00) |=> ctr_q[$past(upd_idx)] == 2'b00);

    p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken && upd_cur != 2'b11) |=>
            ctr_q[$past(upd_idx)] == $past(upd_cur) + 2'd1);

endmodule

// File: rtl/local_branch_predictor.sv
module local_branch_predictor #(
    parameter int ADDR_W  = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 10,
    parameter int TAG_W   = 8,
    parameter int HIST_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_hit,
    output logic              fetch_taken,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_addr,
    input  logic              res_taken
);
    localparam int TAG_LSB = IDX_LSB + IDX_W;

    logic [IDX_W-1:0]  f_idx,  r_idx;
    logic [TAG_W-1:0]  f_tag,  r_tag;
    logic [HIST_W-1:0] f_low,  r_low;
    logic [HIST_W-1:0] f_hist, r_hist;
    logic              f_hit,  r_hit;
    logic              f_ctr_taken;

    always_comb begin
        f_idx = fetch_addr[IDX_LSB +: IDX_W];
        f_tag = fetch_addr[TAG_LSB +: TAG_W];
        f_low = fetch_addr[IDX_LSB +: HIST_W];
        r_idx = res_addr[IDX_LSB +: IDX_W];
        r_tag = res_addr[TAG_LSB +: TAG_W];
        r_low = res_addr[IDX_LSB +: HIST_W];
    end

    lbp_hist_cache #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .HIST_W(HIST_W)
    ) hcache_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (f_idx),
        .rd_tag  (f_tag),
        .rd_hit  (f_hit),
        .rd_hist (f_hist),
        .wr_en   (res_valid),
        .wr_idx  (r_idx),
        .wr_tag  (r_tag),
        .wr_taken(res_taken),
        .wr_hit  (r_hit),
        .wr_hist (r_hist)
    );

    lbp_ctr_table #(
        .CIDX_W(HIST_W)
    ) ctab_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (f_hist ^ f_low),
        .rd_taken (f_ctr_taken),
        .upd_en   (res_valid && r_hit),
        .upd_idx  (r_hist ^ r_low),
        .upd_taken(res_taken)
    );

    always_comb begin
        fetch_hit   = f_hit;
        fetch_taken = f_hit ? f_ctr_taken : 1'b1;
    end

    p_miss_hit_later_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && fetch_addr == res_addr) |=>
            (fetch_hit || fetch_addr != $past(fetch_addr)));

endmodule

// File: tb/local_branch_predictor_tb.sv
module local_branch_predictor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 37;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_hit, fetch_taken;
    logic        res_valid = 1'b0;
    logic [31:0] res_addr = '0;
    logic        res_taken = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    local_branch_predictor dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_addr (fetch_addr),
        .fetch_hit  (fetch_hit),
        .fetch_taken(fetch_taken),
        .res_valid  (res_valid),
        .res_addr   (res_addr),
        .res_taken  (res_taken)
    );

    localparam logic [31:0] A_ = 32'h0000_1004; // idx 1,  tag 1, low 1
    localparam logic [31:0] B_ = 32'h0010_1004; // aliases A above the tag
    localparam logic [31:0] C_ = 32'h0000_2004; // idx 1,  tag 2, low 1
    localparam logic [31:0] E_ = 32'h0000_100C; // idx 3,  low 3
    localparam logic [31:0] G_ = 32'h0000_1104; // idx 65, low 1
    localparam logic [31:0] H_ = 32'h0000_1204; // idx 129, low 1
    localparam logic [31:0] J_ = 32'h0000_10F4; // low 61
    localparam logic [31:0] K_ = 32'h0000_14F4; // low 61
    localparam logic [31:0] L_ = 32'h0000_18F4; // low 61

    // {is_resolve, addr, taken, exp_hit, exp_taken, req}
    localparam logic [39:0] VEC [NVEC] = '{
        {1'b0, A_, 1'b0, 1'b0, 1'b1, 4'd2}, // R2 cold miss
        {1'b1, A_, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 allocate, hist 0
        {1'b0, A_, 1'b0, 1'b1, 1'b1, 4'd4}, // R4 ctr1 = 10
        {1'b1, A_, 1'b0, 1'b0, 1'b0, 4'd5}, // ctr1 -> 01
        {1'b0, A_, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 decrement seen
        {1'b1, A_, 1'b0, 1'b0, 1'b0, 4'd5}, // ctr1 -> 00
        {1'b1, A_, 1'b0, 1'b0, 1'b0, 4'd5}, // ctr1 stays 00
        {1'b1, A_, 1'b1, 1'b0, 1'b0, 4'd6}, // ctr1 -> 01, hist 1
        {1'b0, A_, 1'b0, 1'b1, 1'b1, 4'd6}, // R6 index 1^1 = 0
        {1'b1, A_, 1'b1, 1'b0, 1'b0, 4'd6}, // ctr0 -> 11, hist 3
        {1'b0, A_, 1'b0, 1'b1, 1'b1, 4'd6}, // R6 index 3^1 = 2
        {1'b0, B_, 1'b0, 1'b1, 1'b1, 4'd3}, // R3 false hit
        {1'b1, G_, 1'b0, 1'b0, 1'b0, 4'd7}, // allocate G, hist 0
        {1'b0, G_, 1'b0, 1'b1, 1'b0, 4'd9}, // R9 shared ctr1 = 01
        {1'b1, G_, 1'b1, 1'b0, 1'b0, 4'd5}, // ctr1 -> 10
        {1'b1, H_, 1'b0, 1'b0, 1'b0, 4'd7}, // allocate H
        {1'b0, H_, 1'b0, 1'b1, 1'b1, 4'd5}, // R5 low saturation: ctr1 = 10
        {1'b0, C_, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 tag conflict misses
        {1'b1, C_, 1'b0, 1'b0, 1'b0, 4'd7}, // evict A
        {1'b0, A_, 1'b0, 1'b0, 1'b1, 4'd7}, // R7 A evicted
        {1'b0, C_, 1'b0, 1'b1, 1'b1, 4'd7}, // R7 no ctr change on alloc
        {1'b1, E_, 1'b1, 1'b0, 1'b0, 4'd7}, // allocate E, hist 1
        {1'b1, E_, 1'b1, 1'b0, 1'b0, 4'd5},
        {1'b1, E_, 1'b1, 1'b0, 1'b0, 4'd5},
        {1'b1, E_, 1'b1, 1'b0, 1'b0, 4'd5},
        {1'b1, E_, 1'b1, 1'b0, 1'b0, 4'd5},
        {1'b1, E_, 1'b1, 1'b0, 1'b0, 4'd5}, // hist 111111
        {1'b1, E_, 1'b1, 1'b0, 1'b0, 4'd5}, // ctr60 -> 11
        {1'b1, E_, 1'b1, 1'b0, 1'b0, 4'd5}, // ctr60 stays 11
        {1'b1, J_, 1'b1, 1'b0, 1'b0, 4'd7}, // J hist 1 -> index 60
        {1'b0, J_, 1'b0, 1'b1, 1'b1, 4'd5}, // R5 high saturation
        {1'b1, J_, 1'b0, 1'b0, 1'b0, 4'd5}, // ctr60 -> 10
        {1'b1, K_, 1'b1, 1'b0, 1'b0, 4'd7},
        {1'b0, K_, 1'b0, 1'b1, 1'b1, 4'd5}, // R5 ctr60 = 10
        {1'b1, K_, 1'b0, 1'b0, 1'b0, 4'd5}, // ctr60 -> 01
        {1'b1, L_, 1'b1, 1'b0, 1'b0, 4'd7},
        {1'b0, L_, 1'b0, 1'b1, 1'b0, 4'd4}  // R4 ctr60 = 01
    };

    task automatic check_fetch(input logic [31:0] addr, input logic eh, input logic ep,
                               input int req);
        @(negedge clk);
        fetch_addr = addr;
        #(CLK_PERIOD/4);
        checks++;
        if (fetch_hit !== eh || fetch_taken !== ep) begin
            errors++;
            $display("FAIL R%0d addr %h: hit/taken %b%b expected %b%b",
                     req, addr, fetch_hit, fetch_taken, eh, ep);
        end
    endtask

    task automatic resolve(input logic [31:0] addr, input logic t);
        @(negedge clk);
        res_addr  = addr;
        res_taken = t;
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: cold state, nothing hits
        check_fetch(A_, 1'b0, 1'b1, 1);
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][39]) begin
                resolve(VEC[v][38:7], VEC[v][6]);
            end else begin
                check_fetch(VEC[v][38:7], VEC[v][5], VEC[v][4], int'(VEC[v][3:0]));
            end
        end

        // R1: reset after activity clears entries and restores counters
        do_reset();
        check_fetch(E_, 1'b0, 1'b1, 1);
        // R8: resolve inputs without strobe leave G unallocated
        @(negedge clk);
        res_addr  = G_;
        res_taken = 1'b0;
        res_valid = 1'b0;
        repeat (2) @(negedge clk);
        check_fetch(G_, 1'b0, 1'b1, 8);
        resolve(G_, 1'b0);
        // R1: ctr1 back at weakly taken
        check_fetch(G_, 1'b1, 1'b1, 1);

        finish_run();
    end

endmodule